// File: doc/BRIEF.md
# Five-Channel Down-Counting PWM Timer Bank

This block holds five independent down-counters behind a small word-wide register bus. Each channel keeps a count buffer and, except the last, a compare buffer. Neither buffer reaches the live counter on a write. The counter takes the buffered values only while a manual-load control bit is held, or when it reloads itself after hitting zero with auto-reload set.

Each channel advances by one on every cycle in which its external tick enable is high and its run bit is set. On the tick that brings the count from one to zero, the channel raises a sticky status flag. A status flag reaches its interrupt line when the matching enable bit is also set.

Channels 0 to 3 each drive a PWM level, which is high while the live count is at or below the compare value. An invert bit flips that level. Channel 4 is a pure counter: it has no compare stage, no output pin and no invert bit. Two configuration words for the clock dividers are stored and read back, but they do not affect counting, because the ticks arrive from outside.

Top module: `pwm_timer_bank`

## Requirements
- R1: After reset every register reads 0, every live count and compare value is 0, `irq` is 0, and `pwm_out` is all ones because a count of 0 is at or below a compare of 0.
- R2: The prescale word at 0x00 keeps its low 16 bits and the divider word at 0x04 keeps its low 20 bits; all other bits read 0, and neither word changes how the counters step.
- R3: The control word at 0x08 holds one 4-bit group per channel: bit 0 run, bit 1 manual load, bit 2 invert, bit 3 auto-reload. Channel 0 uses bits 3:0 and channel n≥1 uses bits 4(n+1)+3 : 4(n+1). Bits 7:4 and 31:24 read 0, and writing all ones reads back 0x00BFFF0F.
- R4: A count buffer (0x0C+12n) or compare buffer (0x10+12n, n≤3) write is stored, truncated to the counter width, and read back. It does not change the live count until the next manual load or auto-reload.
- R5: While manual load is set, the channel copies its buffers into its counter and compare register on every cycle, and ticks do not decrement the count.
- R6: With run set and manual load clear, each tick lowers the count by one. The live count reads at 0x14+12n for channels 0–3 and at 0x40 for channel 4. A tick on a stopped channel has no effect.
- R7: A tick that finds the count at zero with auto-reload set loads the count buffer and compare buffer as they are at that moment.
- R8: Without auto-reload, a channel at zero stays at zero on later ticks.
- R9: At 0x44, bits 4:0 are per-channel interrupt enables and bits 9:5 are status flags. A flag is set only on the tick that takes the count from 1 to 0.
- R10: Writing 1 to a status bit clears it and writing 0 leaves it unchanged; a set in the same cycle wins over a clear.
- R11: `irq[n]` is high exactly while status flag n and enable bit n are both 1.
- R12: For channels 0–3, `pwm_out[n]` is 1 when count ≤ compare and 0 otherwise, XOR the channel's invert bit.
- R13: Channel 4 has no compare buffer (0x40 is read-only) and no output pin, and its invert bit is not stored; its activity never changes `pwm_out`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| bus_addr | input | 8 | Byte address of the register word |
| bus_wr | input | 1 | Write strobe, one cycle per word |
| bus_wdata | input | 32 | Write data |
| bus_rd | input | 1 | Read strobe; data appears on bus_rdata in the next cycle |
| bus_rdata | output | 32 | Registered read data |
| tick_en | input | 5 | Per-channel count enable, one bit per channel |
| pwm_out | output | 4 | PWM levels of channels 0 to 3 |
| irq | output | 5 | Per-channel interrupt lines |

## Verification
A one-shot channel is stepped through its compare boundary and then past zero. This separates decrement, stop-at-zero, flag set and the level change at count equal to compare. An auto-reload channel gets a new count buffer while it is running; the value read before the wrap and the value read after it show whether a buffer write leaks into the counter early or is picked up only at the reload. Register patterns of all ones and truncated writes expose the uneven control packing, the missing channel-4 invert and compare, and the field widths. Writes of zero, then one, to the status field separate write-one-to-clear from a plain write, and the enable mask is changed on its own to show that it gates the lines but not the flags.

// File: rtl/pwm_bank_pkg.sv
// Package: shared constants and address/bit-layout helpers of the PWM timer bank.
// Assumes a fixed bank of five channels; only the last one lacks a compare stage.
package pwm_bank_pkg;

    localparam int NCH      = 5;
    localparam int NPIN     = NCH - 1;
    localparam int ADDR_W   = 8;
    localparam int DATA_W   = 32;
    localparam int GRP_W    = 4;
    localparam int PRE_W    = 16;
    localparam int DIV_W    = GRP_W * NCH;
    localparam int IRQ_W    = 2 * NCH;

    // bit positions inside one channel control group
    localparam int CB_RUN   = 0;
    localparam int CB_LOAD  = 1;
    localparam int CB_INV   = 2;
    localparam int CB_RLD   = 3;

    localparam logic [ADDR_W-1:0] A_PRESCALE = 8'h00;
    localparam logic [ADDR_W-1:0] A_DIVSEL   = 8'h04;
    localparam logic [ADDR_W-1:0] A_CTRL     = 8'h08;
    localparam logic [ADDR_W-1:0] A_OBS_LAST = 8'h40;
    localparam logic [ADDR_W-1:0] A_IRQ      = 8'h44;

    // lowest control bit of channel n (group 7:4 is skipped)
    function automatic int ctl_base(int n);
        return (n == 0) ? 0 : GRP_W * (n + 1);
    endfunction

    function automatic logic [ADDR_W-1:0] cntb_addr(int n);
        return ADDR_W'(8'h0C + 12 * n);
    endfunction

    function automatic logic [ADDR_W-1:0] cmpb_addr(int n);
        return ADDR_W'(8'h10 + 12 * n);
    endfunction

    function automatic logic [ADDR_W-1:0] obs_addr(int n);
        return (n < NCH - 1) ? ADDR_W'(8'h14 + 12 * n) : A_OBS_LAST;
    endfunction

    // writable control bits: all groups, minus the invert of the pinless channel
    function automatic logic [DATA_W-1:0] ctl_mask();
        logic [DATA_W-1:0] m;
        m = '0;
        for (int n = 0; n < NCH; n++) begin
            for (int b = 0; b < GRP_W; b++) begin
                if (!(n == NCH - 1 && b == CB_INV)) m[ctl_base(n) + b] = 1'b1;
            end
        end
        return m;
    endfunction

endpackage

// File: rtl/pwm_counter.sv
// Module: one down-counter with buffered reload.
// Manual load has priority over counting; at zero it reloads when auto-reload is
// set and holds otherwise. zero_evt marks the tick that takes the count 1 -> 0.
module pwm_counter
    import pwm_bank_pkg::*;
#(
    parameter int CNT_W = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             run,
    input  logic             load,
    input  logic             rld,
    input  logic             tick,
    input  logic [CNT_W-1:0] cntb,
    output logic [CNT_W-1:0] cnt,
    output logic             zero_evt
);

    logic [CNT_W-1:0] cnt_q;
    logic             step;

    assign step     = run && tick && !load;
    assign zero_evt = step && (cnt_q == CNT_W'(1));
    assign cnt      = cnt_q;

    // count register: manual load, decrement, reload at zero or hold
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt_q <= '0;
        end else if (load) begin
            cnt_q <= cntb;
        end else if (step) begin
            if (cnt_q != '0)   cnt_q <= cnt_q - 1'b1;
            else if (rld)      cnt_q <= cntb;
        end
    end

    // R5
    load_copy_chk: assert property (@(posedge clk) disable iff (!rst_n)
        load |=> (cnt_q == $past(cntb)));
    // R6
    step_down_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (step && cnt_q != '0) |=> (cnt_q == $past(cnt_q) - 1'b1));
    // R7
    wrap_reload_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (step && rld && cnt_q == '0) |=> (cnt_q == $past(cntb)));
    // R8
    stop_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!load && !rld && cnt_q == '0) |=> (cnt_q == '0));
    // R6
    idle_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!load && !(run && tick)) |=> $stable(cnt_q));

endmodule

// File: rtl/pwm_chan.sv
// Module: PWM channel = counter plus compare register and output level.
// The compare register loads whenever the counter loads (manual or wrap reload).
module pwm_chan
    import pwm_bank_pkg::*;
#(
    parameter int CNT_W = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             run,
    input  logic             load,
    input  logic             rld,
    input  logic             inv,
    input  logic             tick,
    input  logic [CNT_W-1:0] cntb,
    input  logic [CNT_W-1:0] cmpb,
    output logic [CNT_W-1:0] cnt,
    output logic             zero_evt,
    output logic             level
);

    logic [CNT_W-1:0] cmp_q;
    logic             cmp_take;

    pwm_counter #(.CNT_W(CNT_W)) u_cnt (
        .clk      (clk),
        .rst_n    (rst_n),
        .run      (run),
        .load     (load),
        .rld      (rld),
        .tick     (tick),
        .cntb     (cntb),
        .cnt      (cnt),
        .zero_evt (zero_evt)
    );

    assign cmp_take = load || (run && tick && rld && cnt == '0);

    // compare register: follows the buffer at every counter load
    always_ff @(posedge clk) begin
        if (!rst_n)        cmp_q <= '0;
        else if (cmp_take) cmp_q <= cmpb;
    end

    assign level = (cnt <= cmp_q) ^ inv;

    // R5
    cmp_load_chk: assert property (@(posedge clk) disable iff (!rst_n)
        load |=> (cmp_q == $past(cmpb)));
    // R4
    cmp_keep_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!load && !(run && tick)) |=> $stable(cmp_q));

endmodule

// File: rtl/pwm_irq.sv
// Module: interrupt enables and sticky status flags.
// Status bits are write-one-to-clear; a zero event in the same cycle wins.
module pwm_irq
    import pwm_bank_pkg::*;
(
    input  logic             clk,
    input  logic             rst_n,
    input  logic             wr,
    input  logic [IRQ_W-1:0] wdata,
    input  logic [NCH-1:0]   zero_evt,
    output logic [IRQ_W-1:0] view,
    output logic [NCH-1:0]   irq
);

    logic [NCH-1:0] en_q;
    logic [NCH-1:0] st_q;
    logic [NCH-1:0] clr;

    assign clr = wr ? wdata[IRQ_W-1:NCH] : '0;

    // enable mask: plain write
    always_ff @(posedge clk) begin
        if (!rst_n)  en_q <= '0;
        else if (wr) en_q <= wdata[NCH-1:0];
    end

    // status flags: set by zero events, cleared by written ones
    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= (st_q & ~clr) | zero_evt;
    end

    assign view = {st_q, en_q};
    assign irq  = st_q & en_q;

    // R9
    flag_source_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (zero_evt == '0) |=> ((st_q & ~$past(st_q)) == '0));
    // R10
    w1c_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (wr && zero_evt == '0) |=> ((st_q & $past(wdata[IRQ_W-1:NCH])) == '0));
    // R10
    flag_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !wr |=> ((st_q & $past(st_q)) == $past(st_q)));

endmodule

// File: rtl/pwm_regs.sv
// Module: register file of the bank (config words, control, buffers, read mux).
// Assumes single-cycle write strobes; read data is registered one cycle after bus_rd.
module pwm_regs
    import pwm_bank_pkg::*;
#(
    parameter int CNT_W = 16
) (
    input  logic                       clk,
    input  logic                       rst_n,
    input  logic [ADDR_W-1:0]          bus_addr,
    input  logic                       bus_wr,
    input  logic [DATA_W-1:0]          bus_wdata,
    input  logic                       bus_rd,
    output logic [DATA_W-1:0]          bus_rdata,
    input  logic [NCH-1:0][CNT_W-1:0]  cnt_obs,
    input  logic [IRQ_W-1:0]           irq_view,
    output logic                       irq_wr,
    output logic [NCH-1:0]             run_v,
    output logic [NCH-1:0]             load_v,
    output logic [NCH-1:0]             rld_v,
    output logic [NPIN-1:0]            inv_v,
    output logic [NCH-1:0][CNT_W-1:0]  cntb_v,
    output logic [NPIN-1:0][CNT_W-1:0] cmpb_v
);

    localparam logic [DATA_W-1:0] CTL_MASK = ctl_mask();

    logic [PRE_W-1:0]            pre_q;
    logic [DIV_W-1:0]            div_q;
    logic [DATA_W-1:0]           ctl_q;
    logic [NCH-1:0][CNT_W-1:0]   cntb_q;
    logic [NPIN-1:0][CNT_W-1:0]  cmpb_q;
    logic [DATA_W-1:0]           rd_mux;

    assign irq_wr = bus_wr && (bus_addr == A_IRQ);

    // configuration and control words
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            pre_q <= '0;
            div_q <= '0;
            ctl_q <= '0;
        end else if (bus_wr) begin
            if (bus_addr == A_PRESCALE) pre_q <= bus_wdata[PRE_W-1:0];
            if (bus_addr == A_DIVSEL)   div_q <= bus_wdata[DIV_W-1:0];
            if (bus_addr == A_CTRL)     ctl_q <= bus_wdata & CTL_MASK;
        end
    end

    // count and compare buffers
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cntb_q <= '0;
            cmpb_q <= '0;
        end else if (bus_wr) begin
            for (int n = 0; n < NCH; n++)
                if (bus_addr == cntb_addr(n)) cntb_q[n] <= bus_wdata[CNT_W-1:0];
            for (int n = 0; n < NPIN; n++)
                if (bus_addr == cmpb_addr(n)) cmpb_q[n] <= bus_wdata[CNT_W-1:0];
        end
    end

    // per-channel control bits from the unevenly packed control word
    for (genvar n = 0; n < NCH; n++) begin : g_ctl
        localparam int B = ctl_base(n);
        assign run_v[n]  = ctl_q[B + CB_RUN];
        assign load_v[n] = ctl_q[B + CB_LOAD];
        assign rld_v[n]  = ctl_q[B + CB_RLD];
    end
    for (genvar n = 0; n < NPIN; n++) begin : g_inv
        assign inv_v[n] = ctl_q[ctl_base(n) + CB_INV];
    end

    assign cntb_v = cntb_q;
    assign cmpb_v = cmpb_q;

    // read multiplexer
    always_comb begin
        rd_mux = '0;
        if (bus_addr == A_PRESCALE) rd_mux = DATA_W'(pre_q);
        if (bus_addr == A_DIVSEL)   rd_mux = DATA_W'(div_q);
        if (bus_addr == A_CTRL)     rd_mux = ctl_q;
        if (bus_addr == A_IRQ)      rd_mux = DATA_W'(irq_view);
        for (int n = 0; n < NCH; n++) begin
            if (bus_addr == cntb_addr(n)) rd_mux = DATA_W'(cntb_q[n]);
            if (bus_addr == obs_addr(n))  rd_mux = DATA_W'(cnt_obs[n]);
        end
        for (int n = 0; n < NPIN; n++)
            if (bus_addr == cmpb_addr(n)) rd_mux = DATA_W'(cmpb_q[n]);
    end

    // registered read port
    always_ff @(posedge clk) begin
        if (!rst_n)      bus_rdata <= '0;
        else if (bus_rd) bus_rdata <= rd_mux;
    end

    // R3
    ctl_gap_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (ctl_q & ~CTL_MASK) == '0);

endmodule

// File: rtl/pwm_timer_bank.sv
// Module: top of the five-channel PWM timer bank.
// Channels 0..NPIN-1 have compare and output; the last channel is a bare counter.
module pwm_timer_bank
    import pwm_bank_pkg::*;
#(
    parameter int CNT_W = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic              bus_wr,
    input  logic [DATA_W-1:0] bus_wdata,
    input  logic              bus_rd,
    output logic [DATA_W-1:0] bus_rdata,
    input  logic [NCH-1:0]    tick_en,
    output logic [NPIN-1:0]   pwm_out,
    output logic [NCH-1:0]    irq
);

    logic [NCH-1:0][CNT_W-1:0]  cnt_v;
    logic [NCH-1:0][CNT_W-1:0]  cntb_v;
    logic [NPIN-1:0][CNT_W-1:0] cmpb_v;
    logic [NCH-1:0]             run_v, load_v, rld_v, zev;
    logic [NPIN-1:0]            inv_v;
    logic [IRQ_W-1:0]           irq_view;
    logic                       irq_wr;

    pwm_regs #(.CNT_W(CNT_W)) u_regs (
        .clk       (clk),
        .rst_n     (rst_n),
        .bus_addr  (bus_addr),
        .bus_wr    (bus_wr),
        .bus_wdata (bus_wdata),
        .bus_rd    (bus_rd),
        .bus_rdata (bus_rdata),
        .cnt_obs   (cnt_v),
        .irq_view  (irq_view),
        .irq_wr    (irq_wr),
        .run_v     (run_v),
        .load_v    (load_v),
        .rld_v     (rld_v),
        .inv_v     (inv_v),
        .cntb_v    (cntb_v),
        .cmpb_v    (cmpb_v)
    );

    for (genvar n = 0; n < NPIN; n++) begin : g_pin
        pwm_chan #(.CNT_W(CNT_W)) u_chan (
            .clk      (clk),
            .rst_n    (rst_n),
            .run      (run_v[n]),
            .load     (load_v[n]),
            .rld      (rld_v[n]),
            .inv      (inv_v[n]),
            .tick     (tick_en[n]),
            .cntb     (cntb_v[n]),
            .cmpb     (cmpb_v[n]),
            .cnt      (cnt_v[n]),
            .zero_evt (zev[n]),
            .level    (pwm_out[n])
        );
    end

    pwm_counter #(.CNT_W(CNT_W)) u_last (
        .clk      (clk),
        .rst_n    (rst_n),
        .run      (run_v[NCH-1]),
        .load     (load_v[NCH-1]),
        .rld      (rld_v[NCH-1]),
        .tick     (tick_en[NCH-1]),
        .cntb     (cntb_v[NCH-1]),
        .cnt      (cnt_v[NCH-1]),
        .zero_evt (zev[NCH-1])
    );

    pwm_irq u_irq (
        .clk      (clk),
        .rst_n    (rst_n),
        .wr       (irq_wr),
        .wdata    (bus_wdata[IRQ_W-1:0]),
        .zero_evt (zev),
        .view     (irq_view),
        .irq      (irq)
    );

endmodule

// File: tb/tb_pwm_timer_bank.sv
// Bench: scoreboard of expected read data; driver tasks queue expectations, a
// monitor compares bus_rdata one cycle after each read strobe.
module tb_pwm_timer_bank;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [7:0]  bus_addr = '0;
    logic        bus_wr = 1'b0;
    logic [31:0] bus_wdata = '0;
    logic        bus_rd = 1'b0;
    logic [31:0] bus_rdata;
    logic [4:0]  tick_en = '0;
    logic [3:0]  pwm_out;
    logic [4:0]  irq;

    int checks = 0;
    int fails  = 0;
    bit done   = 1'b0;
    logic [31:0] exp_q[$];
    string       tag_q[$];

    always #4 clk = ~clk;

    pwm_timer_bank #(.CNT_W(16)) dut (
        .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_wr(bus_wr),
        .bus_wdata(bus_wdata), .bus_rd(bus_rd), .bus_rdata(bus_rdata),
        .tick_en(tick_en), .pwm_out(pwm_out), .irq(irq)
    );

    task automatic chk(input logic [31:0] got, input logic [31:0] exp, input string tag);
        checks++;
        if (got !== exp) begin
            fails++;
            $display("FAIL %s actual=%h expected=%h", tag, got, exp);
        end
    endtask

    task automatic wr(input logic [7:0] a, input logic [31:0] d);
        bus_addr = a; bus_wdata = d; bus_wr = 1'b1;
        @(negedge clk);
        bus_wr = 1'b0;
    endtask

    task automatic rd(input logic [7:0] a, input logic [31:0] exp, input string tag);
        exp_q.push_back(exp);
        tag_q.push_back(tag);
        bus_addr = a; bus_rd = 1'b1;
        @(negedge clk);
        bus_rd = 1'b0;
    endtask

    task automatic ticks(input logic [4:0] m, input int k);
        for (int i = 0; i < k; i++) begin
            tick_en = m;
            @(negedge clk);
        end
        tick_en = '0;
    endtask

    // monitor: compare read data in the cycle after each strobe
    initial begin
        logic [31:0] e;
        string t;
        forever begin
            @(posedge clk);
            if (bus_rd) begin
                @(negedge clk);
                if (exp_q.size() == 0) begin
                    checks++; fails++;
                    $display("FAIL scoreboard empty actual=%h expected=none", bus_rdata);
                end else begin
                    e = exp_q.pop_front();
                    t = tag_q.pop_front();
                    chk(bus_rdata, e, t);
                end
            end
        end
    end

    // watchdog
    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            fails++;
            $display("FAIL watchdog actual=hung expected=finished");
            $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
            $finish;
        end
    end

    initial begin
        repeat (4) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);

        // R1 reset state
        chk(32'(pwm_out), 32'hF, "R1 pwm_out after reset");
        chk(32'(irq), 32'h0, "R1 irq after reset");
        rd(8'h08, 32'h0, "R1 control after reset");
        rd(8'h44, 32'h0, "R1 irq reg after reset");
        rd(8'h14, 32'h0, "R1 count0 after reset");
        rd(8'h18, 32'h0, "R1 cntbuf1 after reset");

        // R2 config widths
        wr(8'h00, 32'hFFFF_FFFF);
        rd(8'h00, 32'h0000_FFFF, "R2 prescale width");
        wr(8'h04, 32'hFFFF_FFFF);
        rd(8'h04, 32'h000F_FFFF, "R2 divider width");

        // R3 control packing
        wr(8'h08, 32'hFFFF_FFFF);
        rd(8'h08, 32'h00BF_FF0F, "R3 control mask");
        wr(8'h08, 32'h0);

        // R4 buffers
        wr(8'h18, 32'h0001_2345);
        rd(8'h18, 32'h0000_2345, "R4 cntbuf truncation");
        wr(8'h18, 32'd10);
        wr(8'h1C, 32'd4);
        rd(8'h20, 32'd0, "R4 buffer write leaves count");
        rd(8'h1C, 32'd4, "R4 cmpbuf readback");

        // R5 manual load blocks ticks
        wr(8'h08, 32'h0000_0300);
        ticks(5'b00010, 3);
        rd(8'h20, 32'd10, "R5 load copies buffer, ticks ignored");
        chk(32'(pwm_out[1]), 32'd0, "R12 count 10 above compare 4");

        // R6 counting (prescale word all ones has no effect, R2)
        wr(8'h08, 32'h0000_0100);
        ticks(5'b00010, 3);
        rd(8'h20, 32'd7, "R6 three ticks R2 no prescale effect");
        chk(32'(pwm_out[1]), 32'd0, "R12 count 7 above compare");
        ticks(5'b00010, 3);
        chk(32'(pwm_out[1]), 32'd1, "R12 count equals compare");
        wr(8'h18, 32'd50);
        rd(8'h20, 32'd4, "R4 running count untouched by buffer write");
        ticks(5'b00010, 2);
        rd(8'h20, 32'd2, "R6 continue down");
        wr(8'h08, 32'h0000_0500);
        chk(32'(pwm_out[1]), 32'd0, "R12 invert flips level");

        // R9 R11 one-shot reach zero
        wr(8'h44, 32'h0000_0002);
        rd(8'h44, 32'h0000_0002, "R9 enable field");
        ticks(5'b00010, 2);
        rd(8'h44, 32'h0000_0042, "R9 status on reaching zero");
        chk(32'(irq), 32'h2, "R11 line follows flag and enable");
        ticks(5'b00010, 3);
        rd(8'h20, 32'd0, "R8 one-shot holds zero");

        // R10 write-one-to-clear
        wr(8'h44, 32'h0000_0002);
        rd(8'h44, 32'h0000_0042, "R10 zero write keeps flag");
        wr(8'h44, 32'h0000_0042);
        rd(8'h44, 32'h0000_0002, "R10 one write clears flag");
        chk(32'(irq), 32'h0, "R11 line drops with flag");
        ticks(5'b00010, 2);
        rd(8'h44, 32'h0000_0002, "R9 no flag while held at zero");

        // R6 stopped channel ignores ticks
        ticks(5'b00100, 3);
        rd(8'h2C, 32'd0, "R6 stopped channel ignores tick");

        // R7 auto-reload on channel 0
        wr(8'h0C, 32'd5);
        wr(8'h10, 32'd2);
        wr(8'h08, 32'h0000_0002);
        wr(8'h08, 32'h0000_0009);
        wr(8'h44, 32'h0000_0001);
        ticks(5'b00001, 5);
        rd(8'h14, 32'd0, "R6 ch0 reached zero");
        rd(8'h44, 32'h0000_0021, "R9 ch0 flag");
        chk(32'(irq), 32'h1, "R11 ch0 line");
        wr(8'h44, 32'h0000_0021);
        ticks(5'b00001, 1);
        rd(8'h14, 32'd5, "R7 wrap reloads buffer");
        wr(8'h0C, 32'd7);
        ticks(5'b00001, 2);
        rd(8'h14, 32'd3, "R4 new buffer not yet used");
        ticks(5'b00001, 4);
        rd(8'h14, 32'd7, "R7 wrap takes new buffer");
        chk(32'(pwm_out[0]), 32'd0, "R12 count 7 above compare 2");
        wr(8'h44, 32'h0000_0000);
        chk(32'(irq), 32'h0, "R11 enable cleared gates line");
        rd(8'h44, 32'h0000_0020, "R11 flag kept when disabled");
        ticks(5'b00001, 5);
        chk(32'(pwm_out[0]), 32'd1, "R12 count 2 at compare");

        // R13 pinless channel
        wr(8'h3C, 32'd6);
        wr(8'h08, 32'h0020_0000);
        wr(8'h08, 32'h0050_0000);
        rd(8'h08, 32'h0010_0000, "R13 ch4 invert not stored");
        ticks(5'b10000, 2);
        rd(8'h40, 32'd4, "R6 ch4 count at 0x40");
        wr(8'h40, 32'd99);
        rd(8'h40, 32'd4, "R13 0x40 read-only");
        chk(32'(pwm_out), 32'hF, "R13 ch4 leaves pins");

        repeat (3) @(negedge clk);
        done = 1'b1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end

endmodule